// File: doc/BRIEF.md
# SMBus Host Controller Register File

This block is the software-facing register bank of an SMBus host controller. Software reaches it through a byte-wide port with separate read and write strobes. The bank holds the status, control, command, target-address, two data bytes, block-data and auxiliary-control registers. It carries the command fields to a separate transaction engine and raises a level interrupt. Status bits are cleared by writing ones to them. The one exception is the host-busy bit, which only hardware clears.

Writing control with the start bit set launches a transaction. The launch is a one-cycle start pulse to the engine. If the same write leaves interrupts disabled, the launch is held back: host-busy is raised at once, and the start pulse is issued only after software next reads status. A control write with the kill bit set aborts the operation. It raises the failed flag, drops host-busy and sends the engine a one-cycle kill pulse. The engine reports back through a per-bit status-set input and a busy-release strobe.

Top module: `smbh_regs_top`

## Requirements
- R1: The command, target-address, data0, data1 and block-data registers sit at byte offsets 0x03, 0x04, 0x05, 0x06 and 0x07. Each returns the last byte written to it and drives its engine output unchanged.
- R2: Status is at offset 0x00. Its bits, from bit 0 up, are host busy, interrupt, device error, bus error, failed, alert, in-use and byte done. Each bit set in `eng_sts_set` sets that status bit at the next clock, and `host_busy_o` mirrors bit 0.
- R3: A status write clears every status bit written as 1, except host busy (bit 0), which a status write never clears. An engine set request in the same cycle wins over the clear.
- R4: Control is at offset 0x02. It holds interrupt enable (bit 0), kill (bit 1), protocol code (bits 4:2), last byte (bit 5) and PEC enable (bit 7). These fields drive `proto_o`, `last_byte_o` and `pec_en_o`.
- R5: A control read returns bits 4:0 of control with bits 7:5 as 0. The start bit (bit 6) is never stored.
- R6: A control write with bit 1 set sets failed, clears host busy and cancels any deferred launch. On the next cycle it produces a one-cycle `eng_kill_o` pulse and no start pulse.
- R7: `irq_o` is 1 exactly when interrupt enable is 1 and some status bit other than host busy is 1.
- R8: A control write with start (bit 6) set and interrupt enable clear sets host busy and gives no start pulse. The next status read returns busy as 1, then clears busy and gives one `eng_start_o` pulse on the following cycle.
- R9: A control write with start and interrupt enable both set gives one `eng_start_o` pulse on the next cycle and leaves host busy unchanged.
- R10: Auxiliary control is at offset 0x0D. It keeps only bit 0 (PEC append) and bit 1 (block-buffer mode); the other bits read as 0.
- R11: Reads of any other offset return 0x00, and writes to them change no register.
- R12: Reset clears status, control, the data registers and any deferred launch. Auxiliary bit 1 resets to `cfg_force_blk` and bit 0 resets to 0.
- R13: Read data appears on `bus_rdata` on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_force_blk | input | 1 | Reset value of auxiliary block-buffer mode |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Level interrupt |
| eng_start_o | output | 1 | Launch pulse to transaction engine |
| eng_kill_o | output | 1 | Abort pulse to transaction engine |
| host_busy_o | output | 1 | Host-busy status bit |
| proto_o | output | 3 | Protocol code |
| last_byte_o | output | 1 | Last-byte control |
| pec_en_o | output | 1 | PEC enable control |
| cmd_o | output | 8 | Command byte |
| tgt_addr_o | output | 8 | Target address byte |
| data0_o | output | 8 | Data byte 0 |
| data1_o | output | 8 | Data byte 1 |
| blk_data_o | output | 8 | Block data byte |
| aux_pec_o | output | 1 | Auxiliary PEC append |
| aux_blk_o | output | 1 | Auxiliary block-buffer mode |
| eng_sts_set | input | 8 | Per-bit status set requests from the engine |
| eng_busy_clr | input | 1 | Engine request to drop host busy |

## Verification
Every register changes at the clock edge that samples the strobe. Read data, the status bits and the engine fields are therefore due one cycle after the stimulus, and the interrupt follows from them in that same cycle. Start and kill pulses are high during exactly the cycle after the write or status read that causes them. The bench drives inputs and compares all outputs on falling edges, against a reference model advanced on each rising edge. Its directed checks sample right after the edge that applies the stimulus, so each result is checked in the first cycle it is due.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

  localparam int DW = 8;

  // byte offsets decoded by software
  localparam int OFS_STS     = 0;
  localparam int OFS_CTL     = 2;
  localparam int PLAIN_BASE  = 3;   // command, target addr, data0, data1, block data
  localparam int PLAIN_N     = 5;
  localparam int OFS_AUX     = 13;

  // status bit positions
  localparam int ST_BUSY   = 0;
  localparam int ST_FAILED = 4;

  // control bit positions
  localparam int CT_IE    = 0;
  localparam int CT_KILL  = 1;
  localparam int CT_PLO   = 2;
  localparam int CT_PHI   = 4;
  localparam int CT_LAST  = 5;
  localparam int CT_GO    = 6;
  localparam int CT_PEC   = 7;

  localparam int AUX_W = 2;

  localparam logic [DW-1:0] BUSY_M   = DW'(1) << ST_BUSY;
  localparam logic [DW-1:0] FAILED_M = DW'(1) << ST_FAILED;
  localparam logic [DW-1:0] GO_M     = DW'(1) << CT_GO;

  // next status: clears first, then sets (sets win)
  function automatic logic [DW-1:0] sts_next(
    input logic [DW-1:0] cur,
    input logic [DW-1:0] w1c,
    input logic          busy_drop,
    input logic [DW-1:0] set_m
  );
    logic [DW-1:0] clr_m;
    clr_m = (w1c & ~BUSY_M) | (busy_drop ? BUSY_M : '0);
    return (cur & ~clr_m) | set_m;
  endfunction

  function automatic logic irq_level(input logic [DW-1:0] sts, input logic ie);
    return ie & (|(sts & ~BUSY_M));
  endfunction

  function automatic logic [DW-1:0] ctl_view(input logic [DW-1:0] ctl);
    return {3'b000, ctl[CT_PHI:0]};
  endfunction

endpackage

// File: rtl/smbh_decode.sv
module smbh_decode
  import smbh_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_sts,
  output logic              wr_ctl,
  output logic              wr_aux,
  output logic [PLAIN_N-1:0] wr_plain,
  output logic              rd_sts,
  output logic              rd_ctl,
  output logic              rd_aux,
  output logic [PLAIN_N-1:0] rd_plain
);

  logic hit_sts, hit_ctl, hit_aux;
  logic [PLAIN_N-1:0] hit_plain;

  assign hit_sts = (addr == ADDR_W'(OFS_STS));
  assign hit_ctl = (addr == ADDR_W'(OFS_CTL));
  assign hit_aux = (addr == ADDR_W'(OFS_AUX));

  for (genvar i = 0; i < PLAIN_N; i++) begin : g_plain
    assign hit_plain[i] = (addr == ADDR_W'(PLAIN_BASE + i));
    assign wr_plain[i]  = wr & hit_plain[i];
    assign rd_plain[i]  = rd & hit_plain[i];
  end

  assign wr_sts = wr & hit_sts;
  assign wr_ctl = wr & hit_ctl;
  assign wr_aux = wr & hit_aux;
  assign rd_sts = rd & hit_sts;
  assign rd_ctl = rd & hit_ctl;
  assign rd_aux = rd & hit_aux;

endmodule

// File: rtl/smbh_cfgregs.sv
module smbh_cfgregs
  import smbh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_force_blk,
  input  logic [DW-1:0]      wdata,
  input  logic               wr_ctl,
  input  logic               wr_aux,
  input  logic [PLAIN_N-1:0] wr_plain,
  output logic [DW-1:0]      ctl_q,
  output logic [AUX_W-1:0]   aux_q,
  output logic [DW-1:0]      plain_q [PLAIN_N]
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q <= wdata & ~GO_M;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aux_q <= {cfg_force_blk, 1'b0};
    end else if (wr_aux) begin
      aux_q <= wdata[AUX_W-1:0];
    end
  end

  for (genvar i = 0; i < PLAIN_N; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        plain_q[i] <= '0;
      end else if (wr_plain[i]) begin
        plain_q[i] <= wdata;
      end
    end
  end

  AST_GO_NEVER_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> !ctl_q[CT_GO]);  // R5

  AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_plain == '0) |=> $stable(plain_q[0]) && $stable(plain_q[PLAIN_N-1]));  // R11

endmodule

// File: rtl/smbh_status.sv
module smbh_status
  import smbh_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] wdata,
  input  logic          wr_sts,
  input  logic          rd_sts,
  input  logic          wr_ctl,
  input  logic [DW-1:0] eng_sts_set,
  input  logic          eng_busy_clr,
  output logic [DW-1:0] sts_q,
  output logic          pend_q,
  output logic          start_q,
  output logic          kill_q
);

  // named events for the assertions
  logic kill_evt, go_evt, defer_evt, now_evt, launch_evt;
  logic busy_drop;
  logic [DW-1:0] w1c_m, set_m;

  assign kill_evt   = wr_ctl & wdata[CT_KILL];
  assign go_evt     = wr_ctl & wdata[CT_GO] & ~kill_evt;
  assign defer_evt  = go_evt & ~wdata[CT_IE];
  assign now_evt    = go_evt & wdata[CT_IE];
  assign launch_evt = rd_sts & pend_q;

  assign w1c_m     = wr_sts ? wdata : '0;
  assign busy_drop = kill_evt | launch_evt | eng_busy_clr;
  assign set_m     = eng_sts_set
                   | (defer_evt ? BUSY_M : '0)
                   | (kill_evt ? FAILED_M : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= '0;
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      kill_q  <= 1'b0;
    end else begin
      sts_q   <= sts_next(sts_q, w1c_m, busy_drop, set_m);
      if (kill_evt || launch_evt || now_evt) begin
        pend_q <= 1'b0;
      end else if (defer_evt) begin
        pend_q <= 1'b1;
      end
      start_q <= now_evt | launch_evt;
      kill_q  <= kill_evt;
    end
  end

  AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && sts_q[ST_BUSY] && !eng_busy_clr) |=> sts_q[ST_BUSY]);  // R3

  AST_W1C_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && wdata[DW-1] && !eng_sts_set[DW-1]) |=> !sts_q[DW-1]);  // R3

  AST_KILL_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_evt && !eng_sts_set[ST_BUSY]) |=> sts_q[ST_FAILED] && !sts_q[ST_BUSY] && !pend_q && kill_q && !start_q);  // R6

  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    defer_evt |=> sts_q[ST_BUSY] && pend_q && !start_q);  // R8

  AST_DEFER_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && pend_q && !eng_sts_set[ST_BUSY]) |=> !sts_q[ST_BUSY] && start_q && !pend_q);  // R8

  AST_NOW_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    now_evt |=> start_q && !pend_q && !kill_q);  // R9

endmodule

// File: rtl/smbh_regs_top.sv
module smbh_regs_top
  import smbh_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_force_blk,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_o,
  output logic              eng_start_o,
  output logic              eng_kill_o,
  output logic              host_busy_o,
  output logic [2:0]        proto_o,
  output logic              last_byte_o,
  output logic              pec_en_o,
  output logic [7:0]        cmd_o,
  output logic [7:0]        tgt_addr_o,
  output logic [7:0]        data0_o,
  output logic [7:0]        data1_o,
  output logic [7:0]        blk_data_o,
  output logic              aux_pec_o,
  output logic              aux_blk_o,
  input  logic [7:0]        eng_sts_set,
  input  logic              eng_busy_clr
);

  logic wr_sts, wr_ctl, wr_aux, rd_sts, rd_ctl, rd_aux;
  logic [PLAIN_N-1:0] wr_plain, rd_plain;
  logic [DW-1:0] ctl_q, sts_q;
  logic [AUX_W-1:0] aux_q;
  logic [DW-1:0] plain_q [PLAIN_N];
  logic pend_q;
  logic rd_any;
  logic [DW-1:0] rd_view;

  smbh_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wr_sts(wr_sts), .wr_ctl(wr_ctl), .wr_aux(wr_aux), .wr_plain(wr_plain),
    .rd_sts(rd_sts), .rd_ctl(rd_ctl), .rd_aux(rd_aux), .rd_plain(rd_plain)
  );

  smbh_cfgregs u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_force_blk(cfg_force_blk),
    .wdata(bus_wdata), .wr_ctl(wr_ctl), .wr_aux(wr_aux), .wr_plain(wr_plain),
    .ctl_q(ctl_q), .aux_q(aux_q), .plain_q(plain_q)
  );

  smbh_status u_sts (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
    .wr_sts(wr_sts), .rd_sts(rd_sts), .wr_ctl(wr_ctl),
    .eng_sts_set(eng_sts_set), .eng_busy_clr(eng_busy_clr),
    .sts_q(sts_q), .pend_q(pend_q), .start_q(eng_start_o), .kill_q(eng_kill_o)
  );

  // read view, unmapped offsets give zero
  always_comb begin
    rd_view = '0;
    if (rd_sts) rd_view = sts_q;
    if (rd_ctl) rd_view = ctl_view(ctl_q);
    if (rd_aux) rd_view = DW'(aux_q);
    for (int i = 0; i < PLAIN_N; i++) begin
      if (rd_plain[i]) rd_view = plain_q[i];
    end
  end

  assign rd_any = rd_sts | rd_ctl | rd_aux | (|rd_plain);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_view;
    end
  end

  assign irq_o       = irq_level(sts_q, ctl_q[CT_IE]);
  assign host_busy_o = sts_q[ST_BUSY];
  assign proto_o     = ctl_q[CT_PHI:CT_PLO];
  assign last_byte_o = ctl_q[CT_LAST];
  assign pec_en_o    = ctl_q[CT_PEC];
  assign cmd_o       = plain_q[0];
  assign tgt_addr_o  = plain_q[1];
  assign data0_o     = plain_q[2];
  assign data1_o     = plain_q[3];
  assign blk_data_o  = plain_q[4];
  assign aux_pec_o   = aux_q[0];
  assign aux_blk_o   = aux_q[1];

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));  // R13

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[CT_IE] |-> !irq_o);  // R7

  AST_IRQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q == BUSY_M) |-> !irq_o);  // R7

  AST_CTL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl |=> (bus_rdata[7:5] == 3'b000));  // R5

  AST_AUX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_aux |=> (bus_rdata[7:AUX_W] == '0));  // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_any) |=> (bus_rdata == 8'h00));  // R11

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !$past(!rst_n)) |=> $stable(bus_rdata));  // R13

endmodule

// File: tb/test_smbh_regs_top.sv
module test_smbh_regs_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_force_blk = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq_o, eng_start_o, eng_kill_o, host_busy_o;
  logic [2:0] proto_o;
  logic last_byte_o, pec_en_o, aux_pec_o, aux_blk_o;
  logic [7:0] cmd_o, tgt_addr_o, data0_o, data1_o, blk_data_o;
  logic [7:0] eng_sts_set = '0;
  logic eng_busy_clr = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbh_regs_top #(.ADDR_W(AW)) i_smbh_regs_top (
    .clk(clk), .rst_n(rst_n), .cfg_force_blk(cfg_force_blk),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .eng_start_o(eng_start_o), .eng_kill_o(eng_kill_o),
    .host_busy_o(host_busy_o), .proto_o(proto_o), .last_byte_o(last_byte_o),
    .pec_en_o(pec_en_o), .cmd_o(cmd_o), .tgt_addr_o(tgt_addr_o),
    .data0_o(data0_o), .data1_o(data1_o), .blk_data_o(blk_data_o),
    .aux_pec_o(aux_pec_o), .aux_blk_o(aux_blk_o),
    .eng_sts_set(eng_sts_set), .eng_busy_clr(eng_busy_clr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_sts, m_ctl, m_aux, m_rdata;
  int m_byte [int];
  bit m_pend, m_start, m_kill;

  function automatic int model_read(input int a);
    case (a)
      0:       return m_sts;
      2:       return m_ctl % 32;
      13:      return m_aux;
      3, 4, 5, 6, 7: return m_byte[a];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int a, d, nxt;
    bit kill, go, launch;
    if (!rst_n) begin
      m_sts = 0; m_ctl = 0; m_rdata = 0;
      m_aux = cfg_force_blk ? 2 : 0;
      for (int k = 3; k <= 7; k++) m_byte[k] = 0;
      m_pend = 0; m_start = 0; m_kill = 0;
    end else begin
      a = int'(bus_addr);
      d = int'(bus_wdata);
      if (bus_rd) m_rdata = model_read(a);
      kill   = bus_wr && a == 2 && d[1];
      go     = bus_wr && a == 2 && d[6] && !kill;
      launch = bus_rd && a == 0 && m_pend;
      nxt = m_sts;
      if (bus_wr && a == 0) nxt = nxt & ~(d & 'hFE);
      if (kill || launch || eng_busy_clr) nxt = nxt & 'hFE;
      nxt = nxt | int'(eng_sts_set);
      if (go && !d[0]) nxt = nxt | 1;
      if (kill) nxt = nxt | 'h10;
      m_sts = nxt;
      m_start = (go && d[0]) || launch;
      m_kill = kill;
      if (kill || launch || (go && d[0])) m_pend = 0;
      else if (go) m_pend = 1;
      if (bus_wr && a == 2) m_ctl = d & 'hBF;
      if (bus_wr && a == 13) m_aux = d % 4;
      if (bus_wr && a >= 3 && a <= 7) m_byte[a] = d;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      check(bus_rdata == 8'(m_rdata), "R13 read data", bus_rdata, m_rdata);
      check(irq_o == ((m_ctl % 2 == 1) && ((m_sts & 'hFE) != 0)), "R7 irq", irq_o, irq_o ^ 1'b1);
      check(eng_start_o == m_start, "R9 start pulse", eng_start_o, m_start);
      check(eng_kill_o == m_kill, "R6 kill pulse", eng_kill_o, m_kill);
      check(host_busy_o == m_sts[0], "R2 busy", host_busy_o, m_sts[0]);
      check(proto_o == 3'((m_ctl >> 2) % 8), "R4 protocol", proto_o, (m_ctl >> 2) % 8);
      check({pec_en_o, last_byte_o} == {m_ctl[7], m_ctl[5]}, "R4 pec/last", {pec_en_o, last_byte_o}, {m_ctl[7], m_ctl[5]});
      check({aux_blk_o, aux_pec_o} == 2'(m_aux), "R10 aux out", {aux_blk_o, aux_pec_o}, m_aux);
      check(data0_o == 8'(m_byte[5]) && blk_data_o == 8'(m_byte[7]), "R1 engine bytes", data0_o, m_byte[5]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_expect(input int a, input int exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    check(bus_rdata == 8'(exp), tag, bus_rdata, exp);
  endtask

  task automatic eng(input int set_m, input bit clr);
    @(negedge clk);
    eng_sts_set = 8'(set_m); eng_busy_clr = clr;
    @(negedge clk);
    eng_sts_set = '0; eng_busy_clr = 1'b0;
  endtask

  task automatic do_reset(input bit force_blk);
    @(negedge clk);
    rst_n = 1'b0; cfg_force_blk = force_blk;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(1'b1);
    cmp_on = 1;
    // R12 reset state
    rd_expect(13, 'h02, "R12 aux reset with force");
    rd_expect(0, 'h00, "R12 status reset");
    check(irq_o == 1'b0, "R12 irq at reset", irq_o, 0);

    // R1 plain registers
    wr(3, 'h3C); wr(4, 'hA5); wr(5, 'h11); wr(6, 'h22); wr(7, 'h33);
    rd_expect(3, 'h3C, "R1 command");
    rd_expect(4, 'hA5, "R1 target address");
    rd_expect(5, 'h11, "R1 data0");
    rd_expect(6, 'h22, "R1 data1");
    rd_expect(7, 'h33, "R1 block data");
    check(cmd_o == 8'h3C && tgt_addr_o == 8'hA5 && data1_o == 8'h22, "R1 outputs", cmd_o, 'h3C);

    // R11 unmapped
    wr(8, 'hFF); wr(1, 'hFF);
    rd_expect(8, 'h00, "R11 unmapped 0x08");
    rd_expect(1, 'h00, "R11 unmapped 0x01");
    rd_expect(7, 'h33, "R11 write ignored");

    // R10 aux
    wr(13, 'hFF);
    rd_expect(13, 'h03, "R10 aux keeps two bits");

    // R4 / R5 control fields
    wr(2, 'hBD);
    check(proto_o == 3'd7 && last_byte_o && pec_en_o, "R4 control fields", proto_o, 7);
    rd_expect(2, 'h1D, "R5 control readback");
    check(eng_start_o == 1'b0, "R5 no start on plain write", eng_start_o, 0);

    // R9 immediate start
    wr(2, 'h41);
    check(eng_start_o == 1'b1 && host_busy_o == 1'b0, "R9 immediate start", eng_start_o, 1);
    rd_expect(2, 'h01, "R5 start reads zero");

    // R2 / R3 / R7 status
    eng('h83, 1'b0);
    check(irq_o == 1'b1, "R7 irq on done", irq_o, 1);
    rd_expect(0, 'h83, "R2 engine set bits");
    wr(0, 'hFF);
    rd_expect(0, 'h01, "R3 busy survives w1c");
    check(irq_o == 1'b0, "R7 busy alone no irq", irq_o, 0);
    eng(0, 1'b1);
    rd_expect(0, 'h00, "R2 engine busy release");

    // R8 deferred start
    wr(2, 'h40);
    check(host_busy_o == 1'b1 && eng_start_o == 1'b0, "R8 deferred busy", host_busy_o, 1);
    rd_expect(0, 'h01, "R8 status read shows busy");
    check(eng_start_o == 1'b1 && host_busy_o == 1'b0, "R8 launch after read", eng_start_o, 1);
    rd_expect(0, 'h00, "R8 second read no busy");
    check(eng_start_o == 1'b0, "R8 single launch", eng_start_o, 0);

    // R6 kill
    wr(2, 'h40);
    wr(2, 'h02);
    check(eng_kill_o == 1'b1 && host_busy_o == 1'b0, "R6 kill pulse", eng_kill_o, 1);
    rd_expect(0, 'h10, "R6 failed set");
    check(eng_start_o == 1'b0, "R6 deferred launch cancelled", eng_start_o, 0);
    check(irq_o == 1'b0, "R7 irq masked", irq_o, 0);
    wr(2, 'h01);
    check(irq_o == 1'b1, "R7 irq enabled", irq_o, 1);
    wr(0, 'h10);
    check(irq_o == 1'b0, "R7 irq cleared", irq_o, 0);

    // R12 reset without force
    cmp_on = 0;
    do_reset(1'b0);
    cmp_on = 1;
    rd_expect(13, 'h00, "R12 aux reset no force");
    rd_expect(5, 'h00, "R12 data cleared");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule